// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Bus

This block is a byte-wide register file that a host reaches over an SMBus-style two-wire link. The link is slow compared with the system clock, so the slave samples SCL and SDA on the system clock. It pulls SDA low through an open-drain enable and never holds SCL. Every register is also presented as a flat parallel vector, so that neighbouring logic can use the configuration directly.

A host writes by sending the write address, a starting register index, a length byte and then the payload bytes. The payload bytes land at consecutive indices. A host reads by setting the index in the same way and then issuing a repeated start with the read address. The slave answers with the content of its length register, followed by registers from the chosen index upward. If the top bit of the length byte in a write frame is set, the low seven bits replace the stored read length. This lets a host choose how many bytes it wants and read them within one transaction.

Top module: `smbus_idx_regs`

## Requirements
- R1: After reset, register 8 (the read length register) holds 0Fh and every other register holds 00h.
- R2: Address byte D2h (write) and D3h (read) are acknowledged. Any other address byte is not acknowledged, and every later byte up to the next start is also left unacknowledged.
- R3: In a write frame, the byte after D2h sets the index and the next byte is the length (bit 7 = 0). Each data byte is then acknowledged and stored at the index, and the index advances by one after each byte.
- R4: A length byte of 00h is not acknowledged, and no data byte that follows it is stored.
- R5: Data bytes beyond the stated length are not acknowledged and are not stored.
- R6: A length byte with bit 7 = 1 is acknowledged and its bits 6..0 go into register 8. Bytes that follow it before a new start are not acknowledged and are not stored.
- R7: After D3h, the slave first sends register 8 and then the registers from the current index upward. It keeps sending while the host acknowledges, and releases SDA after the host's not-acknowledge.
- R8: Bit 7 of register 8 always reads 0, even when a write carries a 1 there.
- R9: The index is 8 bits wide and wraps from FFh to 00h. Writes to indices at or beyond the register count are dropped, and reads from those indices return 00h.
- R10: SDA falling while SCL is high is a start. SDA rising while SCL is high is a stop. A start at any point aborts the current frame, and a stop returns the slave to idle with SDA released.
- R11: The slave changes its SDA drive only while it sees SCL low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_flat | output | REG_COUNT*8 | All registers, register i at bits i*8+7..i*8 |

## Verification
The assertions assume a host that obeys the bus rules. SCL holds each level for several system clocks. SDA changes only while SCL is low, except at deliberate starts and stops. The host releases SDA whenever the slave may drive it. The stimulus enforces this by construction: each SCL phase lasts eight clocks, and SDA moves four clocks after SCL falls. Every start and stop raises SCL before it moves SDA. Frames deliberately include illegal addresses, zero lengths and overlong payloads, but never a glitch on the lines.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
// Shared types for the indexed block register slave.
// Assumes byte-wide registers and an 8-bit index.
package smb_pkg;
    localparam int BYTE_W = 8;

    // Transfer engine states.
    typedef enum logic [2:0] {
        S_IDLE,   // no frame in progress
        S_RX,     // shifting in a byte from the host
        S_ACK,    // ninth clock after a received byte
        S_TX,     // shifting out a byte to the host
        S_MACK,   // ninth clock after a sent byte, host answers
        S_SKIP    // ignore everything until the next start
    } st_t;

    // Which byte of a write frame is being received.
    typedef enum logic [1:0] {
        F_ADDR,
        F_OFFS,
        F_CNT,
        F_DATA
    } fld_t;
endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
// Brings SCL and SDA into the clock domain and finds bus events.
// Assumes both lines idle high and hold each level for several clocks.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains, reset to the idle-high bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // One-cycle-old copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_reg_bank.sv
`timescale 1ns/1ps
// Register array with one write port, one read port and a side port
// that loads the read length register. Indices past REG_COUNT are dropped.
// Assumes a write pulse and a length load never occur in the same cycle.
module smb_reg_bank #(
    parameter int          REG_COUNT = 16,
    parameter int          ADDR_W    = 8,
    parameter int          CNT_IDX   = 8,
    parameter logic [7:0]  CNT_INIT  = 8'h0F
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    input  logic                   rc_ld,
    input  logic [6:0]             rc_val,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [7:0]             rd_data,
    output logic [7:0]             rc_out,
    output logic [REG_COUNT*8-1:0] reg_flat
);
    localparam int              IDX_W = $clog2(REG_COUNT);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(REG_COUNT);

    logic [7:0] regs [REG_COUNT];

    for (genvar gi = 0; gi < REG_COUNT; gi++) begin : g_reg
        localparam logic [7:0] INIT = (gi == CNT_IDX) ? CNT_INIT : 8'h00;
        localparam logic [7:0] MASK = (gi == CNT_IDX) ? 8'h7F : 8'hFF;
        // Holds one register; the length register also accepts side loads.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[gi] <= INIT;
            end else if (wr_en && wr_addr == ADDR_W'(gi)) begin
                regs[gi] <= wr_data & MASK;
            end else if (rc_ld && gi == CNT_IDX) begin
                regs[gi] <= {1'b0, rc_val};
            end
        end
        assign reg_flat[gi*8 +: 8] = regs[gi];
    end

    // Read port returns zero outside the array.
    always_comb begin
        if (rd_addr < LIMIT) rd_data = regs[rd_addr[IDX_W-1:0]];
        else                 rd_data = 8'h00;
    end

    assign rc_out = regs[CNT_IDX];
endmodule

// File: rtl/smb_xfer_engine.sv
`timescale 1ns/1ps
// Bit and byte sequencer: decodes write and read frames, drives
// acknowledges and read data, and advances the register index.
// Assumes synchronized lines and single-cycle event pulses from smb_line_sync.
module smb_xfer_engine
    import smb_pkg::*;
#(
    parameter int         ADDR_W  = 8,
    parameter logic [7:0] WR_ADDR = 8'hD2,
    parameter logic [7:0] RD_ADDR = 8'hD3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [7:0]        rd_data,
    input  logic [7:0]        rcount,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              rc_ld,
    output logic [6:0]        rc_val,
    output logic [ADDR_W-1:0] ptr,
    output st_t               st
);
    fld_t       fld;
    logic [2:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] tx_sr;
    logic [6:0] remain;
    logic       got;
    st_t        plan_st;
    logic       plan_txc;

    logic       dec_ack;
    st_t        dec_st;
    fld_t       dec_fld;
    logic       dec_txc;
    logic [7:0] tx_val;

    // Decides the answer to a completed byte from the frame position.
    always_comb begin
        dec_ack = 1'b0;
        dec_st  = S_SKIP;
        dec_fld = fld;
        dec_txc = 1'b0;
        unique case (fld)
            F_ADDR: begin
                if (shreg == WR_ADDR) begin
                    dec_ack = 1'b1;
                    dec_st  = S_RX;
                    dec_fld = F_OFFS;
                end else if (shreg == RD_ADDR) begin
                    dec_ack = 1'b1;
                    dec_st  = S_TX;
                    dec_txc = 1'b1;
                end
            end
            F_OFFS: begin
                dec_ack = 1'b1;
                dec_st  = S_RX;
                dec_fld = F_CNT;
            end
            F_CNT: begin
                if (shreg != 8'h00) begin
                    dec_ack = 1'b1;
                    if (!shreg[7]) begin
                        dec_st  = S_RX;
                        dec_fld = F_DATA;
                    end
                end
            end
            F_DATA: begin
                if (remain != 7'd0) begin
                    dec_ack = 1'b1;
                    dec_st  = S_RX;
                end
            end
            default: ;
        endcase
    end

    // First byte of a read is the length register, later ones come from the index.
    assign tx_val = plan_txc ? rcount : rd_data;

    // Frame sequencer with open-drain drive control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            fld      <= F_ADDR;
            bitcnt   <= 3'd0;
            shreg    <= 8'h00;
            tx_sr    <= 8'h00;
            remain   <= 7'd0;
            got      <= 1'b0;
            plan_st  <= S_IDLE;
            plan_txc <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= 8'h00;
            rc_ld    <= 1'b0;
            rc_val   <= 7'd0;
            ptr      <= '0;
        end else begin
            wr_en <= 1'b0;
            rc_ld <= 1'b0;
            if (start_det) begin
                st     <= S_RX;
                fld    <= F_ADDR;
                bitcnt <= 3'd0;
                got    <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                st     <= S_IDLE;
                got    <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    S_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) got <= 1'b1;
                        end else if (scl_fall && got) begin
                            got      <= 1'b0;
                            st       <= S_ACK;
                            sda_oe   <= dec_ack;
                            plan_st  <= dec_st;
                            plan_txc <= dec_txc;
                            fld      <= dec_fld;
                            if (fld == F_OFFS) ptr <= shreg;
                            if (fld == F_CNT) begin
                                if (shreg[7]) begin
                                    rc_ld  <= 1'b1;
                                    rc_val <= shreg[6:0];
                                end else begin
                                    remain <= shreg[6:0];
                                end
                            end
                            if (fld == F_DATA && remain != 7'd0) begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + 1'b1;
                                remain  <= remain - 7'd1;
                            end
                        end
                    end
                    S_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= 3'd0;
                            st     <= plan_st;
                            if (plan_st == S_TX) begin
                                tx_sr  <= tx_val;
                                sda_oe <= ~tx_val[7];
                                if (!plan_txc) ptr <= ptr + 1'b1;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    S_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                st     <= S_MACK;
                                got    <= 1'b0;
                            end else begin
                                bitcnt <= bitcnt + 3'd1;
                                tx_sr  <= {tx_sr[6:0], 1'b0};
                                sda_oe <= ~tx_sr[6];
                            end
                        end
                    end
                    S_MACK: begin
                        if (scl_rise) begin
                            if (sda_s) st  <= S_SKIP;
                            else       got <= 1'b1;
                        end else if (scl_fall && got) begin
                            got    <= 1'b0;
                            bitcnt <= 3'd0;
                            tx_sr  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            ptr    <= ptr + 1'b1;
                            st     <= S_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smbus_idx_regs.sv
`timescale 1ns/1ps
// Indexed block register slave on a two-wire bus, oversampled by clk.
// Assumes the bus is much slower than clk and SCL is never stretched.
module smbus_idx_regs
    import smb_pkg::*;
#(
    parameter int         REG_COUNT = 16,
    parameter int         CNT_IDX   = 8,
    parameter logic [7:0] CNT_INIT  = 8'h0F,
    parameter logic [7:0] WR_ADDR   = 8'hD2,
    parameter logic [7:0] RD_ADDR   = 8'hD3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [REG_COUNT*8-1:0] reg_flat
);
    localparam int ADDR_W = BYTE_W;

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              rc_ld;
    logic [6:0]        rc_val;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        rd_data;
    logic [7:0]        rcount;
    st_t               st;

    smb_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_xfer_engine #(.ADDR_W(ADDR_W), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .rcount(rcount), .sda_oe(sda_oe), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rc_ld(rc_ld), .rc_val(rc_val),
        .ptr(ptr), .st(st)
    );

    smb_reg_bank #(.REG_COUNT(REG_COUNT), .ADDR_W(ADDR_W), .CNT_IDX(CNT_IDX),
                   .CNT_INIT(CNT_INIT)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rc_ld(rc_ld), .rc_val(rc_val), .rd_addr(ptr),
        .rd_data(rd_data), .rc_out(rcount), .reg_flat(reg_flat)
    );
endmodule

// File: rtl/smb_idx_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to smbus_idx_regs.
// Assumes a host that keeps to the bus rules stated in the brief.
module smb_idx_chk
    import smb_pkg::*;
#(
    parameter int REG_COUNT = 16,
    parameter int CNT_IDX   = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sda_oe,
    input logic                   scl_s,
    input logic                   stop_det,
    input st_t                    st,
    input logic [REG_COUNT*8-1:0] reg_flat
);
    AST_CNT_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_flat[CNT_IDX*8+7]); // R8

    AST_CNT_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> reg_flat[CNT_IDX*8 +: 8] == 8'h0F); // R1

    AST_SKIP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SKIP) |-> !sda_oe); // R2

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == S_IDLE && !sda_oe)); // R10

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s)); // R11
endmodule

bind smbus_idx_regs smb_idx_chk #(.REG_COUNT(REG_COUNT), .CNT_IDX(CNT_IDX)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
    .stop_det(stop_det), .st(st), .reg_flat(reg_flat)
);

// File: tb/sim_smbus_idx_regs.sv
`timescale 1ns/1ps
// Scoreboard bench: bus tasks push the expected bytes and acknowledges,
// and a monitor compares them with what the bus actually carried.
module sim_smbus_idx_regs;
    localparam int Q  = 40;
    localparam int NR = 16;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scl_m = 1'b1;
    logic             sda_m = 1'b1;
    logic             sda_oe;
    logic [NR*8-1:0]  reg_flat;
    logic             sda_bus;

    item_t      exp_q[$];
    logic [7:0] act_q[$];
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    smbus_idx_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .reg_flat(reg_flat)
    );

    // Compares observed bus items against the expected queue in order.
    initial begin
        forever begin
            wait (act_q.size() > 0);
            begin
                item_t      e;
                logic [7:0] a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                n_cmp++;
                if (a !== e.v) begin
                    n_bad++;
                    $display("FAIL %s: actual %02h expected %02h", e.tag, a, e.v);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] regv(input int i);
        return reg_flat[i*8 +: 8];
    endfunction

    task automatic bus_start();
        #Q sda_m = 1'b1;
        #Q scl_m = 1'b1;
        #Q sda_m = 1'b0;
        #Q scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        #Q sda_m = 1'b0;
        #Q scl_m = 1'b1;
        #Q sda_m = 1'b1;
        #Q;
    endtask

    task automatic bit_out(input logic b);
        #Q sda_m = b;
        #Q scl_m = 1'b1;
        #(2*Q) scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1;
        #(2*Q) scl_m = 1'b1;
        #Q b = sda_bus;
        #Q scl_m = 1'b0;
    endtask

    // Sends one byte; expects 0 for acknowledge, 1 for not-acknowledge.
    task automatic put_byte(input logic [7:0] b, input logic nack, input string tag);
        logic a;
        exp_q.push_back('{v: {7'd0, nack}, tag: tag});
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        act_q.push_back({7'd0, a});
    endtask

    // Receives one byte and answers with an acknowledge unless last is set.
    task automatic get_byte(input logic [7:0] exp, input logic last, input string tag);
        logic [7:0] v;
        exp_q.push_back('{v: exp, tag: tag});
        for (int i = 7; i >= 0; i--) bit_in(v[i]);
        act_q.push_back(v);
        bit_out(last);
        #Q sda_m = 1'b1;
    endtask

    task automatic settle();
        #(8*Q);
        wait (act_q.size() == 0);
    endtask

    // Stimulus.
    initial begin
        #3;
        repeat (4) #10;
        rst_n = 1'b1;
        #20;
        chk("R1 count reg", regv(8), 8'h0F);
        chk("R1 reg0", regv(0), 8'h00);
        chk("R1 reg15", regv(15), 8'h00);
        chk("R1 sda idle", {7'd0, sda_oe}, 8'h00);

        // Plain block write plus one surplus byte.
        bus_start();
        put_byte(8'hD2, 1'b0, "R2 write addr");
        put_byte(8'h02, 1'b0, "R3 index");
        put_byte(8'h03, 1'b0, "R3 length");
        put_byte(8'hA1, 1'b0, "R3 data0");
        put_byte(8'hB2, 1'b0, "R3 data1");
        put_byte(8'hC3, 1'b0, "R3 data2");
        put_byte(8'h5A, 1'b1, "R5 surplus");
        bus_stop();
        settle();
        chk("R3 reg2", regv(2), 8'hA1);
        chk("R3 reg3", regv(3), 8'hB2);
        chk("R3 reg4", regv(4), 8'hC3);
        chk("R5 reg5", regv(5), 8'h00);
        chk("R10 released after stop", {7'd0, sda_oe}, 8'h00);

        // Zero length.
        bus_start();
        put_byte(8'hD2, 1'b0, "R2 write addr");
        put_byte(8'h06, 1'b0, "R3 index");
        put_byte(8'h00, 1'b1, "R4 zero length");
        put_byte(8'h77, 1'b1, "R4 after zero");
        bus_stop();
        settle();
        chk("R4 reg6", regv(6), 8'h00);

        // Foreign address.
        bus_start();
        put_byte(8'hA0, 1'b1, "R2 foreign addr");
        put_byte(8'h06, 1'b1, "R2 ignored byte");
        put_byte(8'h01, 1'b1, "R2 ignored byte");
        bus_stop();
        settle();
        chk("R2 reg6", regv(6), 8'h00);

        // Length update and read in one transaction.
        bus_start();
        put_byte(8'hD2, 1'b0, "R2 write addr");
        put_byte(8'h03, 1'b0, "R3 index");
        put_byte(8'h82, 1'b0, "R6 flagged length");
        put_byte(8'h99, 1'b1, "R6 trailing byte");
        bus_start();
        put_byte(8'hD3, 1'b0, "R2 read addr");
        get_byte(8'h02, 1'b0, "R7 length first");
        get_byte(8'hB2, 1'b0, "R7 data idx3");
        get_byte(8'hC3, 1'b1, "R7 data idx4");
        bus_stop();
        settle();
        chk("R6 count reg", regv(8), 8'h02);
        chk("R6 reg3 kept", regv(3), 8'hB2);
        chk("R7 released after nack", {7'd0, sda_oe}, 8'h00);

        // Reserved top bit of the length register.
        bus_start();
        put_byte(8'hD2, 1'b0, "R2 write addr");
        put_byte(8'h08, 1'b0, "R3 index");
        put_byte(8'h01, 1'b0, "R3 length");
        put_byte(8'hFF, 1'b0, "R8 data");
        bus_stop();
        settle();
        chk("R8 count reg", regv(8), 8'h7F);

        // Standard read with index set first.
        bus_start();
        put_byte(8'hD2, 1'b0, "R2 write addr");
        put_byte(8'h02, 1'b0, "R3 index");
        bus_start();
        put_byte(8'hD3, 1'b0, "R2 read addr");
        get_byte(8'h7F, 1'b0, "R7 R8 length first");
        get_byte(8'hA1, 1'b0, "R7 data idx2");
        get_byte(8'hB2, 1'b1, "R7 data idx3");
        bus_stop();
        settle();

        // Index wrap and out-of-range indices.
        bus_start();
        put_byte(8'hD2, 1'b0, "R2 write addr");
        put_byte(8'hFE, 1'b0, "R9 index");
        put_byte(8'h03, 1'b0, "R9 length");
        put_byte(8'h11, 1'b0, "R9 data FE");
        put_byte(8'h22, 1'b0, "R9 data FF");
        put_byte(8'h33, 1'b0, "R9 data 00");
        bus_stop();
        settle();
        chk("R9 reg0", regv(0), 8'h33);
        chk("R9 reg1", regv(1), 8'h00);
        bus_start();
        put_byte(8'hD2, 1'b0, "R2 write addr");
        put_byte(8'hFF, 1'b0, "R9 index");
        put_byte(8'h84, 1'b0, "R6 flagged length");
        bus_start();
        put_byte(8'hD3, 1'b0, "R2 read addr");
        get_byte(8'h04, 1'b0, "R9 length first");
        get_byte(8'h00, 1'b0, "R9 data FF");
        get_byte(8'h33, 1'b0, "R9 data 00");
        get_byte(8'h00, 1'b1, "R9 data 01");
        bus_stop();
        settle();

        // Repeated start aborts an unfinished write.
        bus_start();
        put_byte(8'hD2, 1'b0, "R2 write addr");
        put_byte(8'h0A, 1'b0, "R3 index");
        put_byte(8'h02, 1'b0, "R3 length");
        put_byte(8'h44, 1'b0, "R10 data");
        bus_start();
        put_byte(8'hD2, 1'b0, "R10 write addr");
        put_byte(8'h0C, 1'b0, "R10 index");
        put_byte(8'h01, 1'b0, "R10 length");
        put_byte(8'h55, 1'b0, "R10 data");
        bus_stop();
        settle();
        chk("R10 reg10", regv(10), 8'h44);
        chk("R10 reg11", regv(11), 8'h00);
        chk("R10 reg12", regv(12), 8'h55);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule